// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Arbiter

This block decides when a small 8-bit controller core must break off its program to serve an interrupt. There are two sources. One is an external request line that is active low and level sensitive, so several open-drain devices can pull it down together. The other is the overflow pulse of the on-chip timer/counter. The external line is looked at only on the clock edge where the core's once-per-machine-cycle address strobe is high. A timer overflow is remembered in a pending flag until it is served.

When a qualifying request is seen on a strobe edge and no interrupt is being served, the block issues a one-clock take pulse. The sequencer treats this pulse as a subroutine call, so the stack block pushes the program counter and status bits. Along with the pulse comes a 12-bit vector: 3 for the external source and 7 for the timer. The block then raises its in-service flag and ignores every request until the core executes its return-with-restore instruction. Only one interrupt level exists.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, and on the edge after, `take`, `in_service` and `vec_addr` are all zero and the timer pending flag is clear.
- R2: If `ext_en` is 1, `ext_req_n` is 0 and `sample_stb` is 1 on an edge while `in_service` is 0, then after that edge `take` is 1 for one clock, `vec_addr` is 3 and `in_service` is 1.
- R3: `take` rises only as a result of an edge on which `sample_stb` was 1. A low external line with no strobe produces no pulse.
- R4: A `tmr_ovf` pulse while `tmr_en` is 1 sets a pending flag. On the next strobe edge with `in_service` 0, `take` pulses with `vec_addr` 7 and the flag clears. An overflow on the strobe edge itself also counts.
- R5: If the external request and a timer request both qualify on the same strobe edge, the external one is taken (vector 3) and the timer request stays pending.
- R6: While `in_service` is 1, no request produces `take`. A `ret_restore` strobe on an edge clears `in_service`. A `ret_restore` strobe while `in_service` is 0 has no effect.
- R7: A source whose enable is 0 never causes `take`. Clearing `tmr_en` drops a pending timer request, and overflows arriving while `tmr_en` is 0 are not kept.
- R8: `take` never stays high for two clocks in a row. Bit 11 of `vec_addr` (the program bank select) is always 0.
- R9: The external line is not latched. A low level that starts and ends between two strobe edges causes no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req_n | input | 1 | Shared external request line, active low, level sensitive |
| tmr_ovf | input | 1 | One-clock overflow pulse from the timer/counter |
| sample_stb | input | 1 | Per-machine-cycle address strobe; the external line is sampled on its edges |
| ext_en | input | 1 | Enable for the external source |
| tmr_en | input | 1 | Enable for the timer source |
| ret_restore | input | 1 | Pulse from the core when it executes return-with-restore |
| take | output | 1 | One-clock pulse: enter the interrupt (push PC and status) |
| vec_addr | output | 12 | Vector address of the accepted source; bank bit forced low |
| in_service | output | 1 | High from acceptance until return-with-restore |

## Verification
The hardest case is the collision. The external line is low and a timer overflow is pending on the same strobe edge, and the test must then confirm that the timer request survives the external service and is taken only after the return. The stimulus first parks an overflow in the pending flag with the strobe held off, then pulls the line low and fires one strobe, releases the line, and returns before the next strobe. A second hard case is an overflow that arrives during service. The stimulus injects it between acceptance and the return, and the cycle-exact reference model then expects vector 7 on the first strobe after the return.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_line_qual.sv
// Qualifies the shared external line with its enable; level, not latched.
module irq_line_qual #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic line_in,
  input  logic enable,
  output logic req
);
  logic asserted;
  generate
    if (ACTIVE_LOW) begin : g_low
      assign asserted = ~line_in;
    end else begin : g_high
      assign asserted = line_in;
    end
  endgenerate
  assign req = enable & asserted;
endmodule

// File: rtl/irq_pend_flag.sv
// Remembers a pulse source until it is accepted or disabled.
module irq_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic enable,
  input  logic accept,
  output logic req
);
  logic pend_q;

  // Request seen by the arbiter includes a pulse arriving this very cycle.
  assign req = enable & (pend_q | pulse);

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (!enable) pend_q <= 1'b0;
    else if (accept)  pend_q <= 1'b0;
    else if (pulse)   pend_q <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed priority: external first, timer second.
module irq_prio_sel
  import irq_vec_pkg::*;
(
  input  logic     ext_req,
  input  logic     tmr_req,
  output irq_src_e winner
);
  always_comb begin
    if (ext_req)      winner = SRC_EXT;
    else if (tmr_req) winner = SRC_TMR;
    else              winner = SRC_NONE;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] EXT_VEC = 12'd3,
  parameter logic [11:0] TMR_VEC = 12'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_req_n,
  input  logic              tmr_ovf,
  input  logic              sample_stb,
  input  logic              ext_en,
  input  logic              tmr_en,
  input  logic              ret_restore,
  output logic              take,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              in_service
);
  localparam int BANK_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] BANK_MASK = ~(ADDR_W'(1) << BANK_BIT);
  localparam logic [ADDR_W-1:0] EXT_A = ADDR_W'(EXT_VEC) & BANK_MASK;
  localparam logic [ADDR_W-1:0] TMR_A = ADDR_W'(TMR_VEC) & BANK_MASK;

  logic     ext_req, tmr_req, accept, tmr_accept;
  irq_src_e winner;

  irq_line_qual #(.ACTIVE_LOW(1'b1)) u_ext (
    .line_in(ext_req_n), .enable(ext_en), .req(ext_req)
  );

  irq_pend_flag u_tmr (
    .clk(clk), .rst(rst), .pulse(tmr_ovf), .enable(tmr_en),
    .accept(tmr_accept), .req(tmr_req)
  );

  irq_prio_sel u_sel (
    .ext_req(ext_req), .tmr_req(tmr_req), .winner(winner)
  );

  assign accept     = sample_stb & ~in_service & (winner != SRC_NONE);
  assign tmr_accept = accept & (winner == SRC_TMR);

  always_ff @(posedge clk) begin
    if (rst) begin
      take       <= 1'b0;
      vec_addr   <= '0;
      in_service <= 1'b0;
    end else begin
      take <= accept;
      if (accept) begin
        in_service <= 1'b1;
        vec_addr   <= (winner == SRC_EXT) ? EXT_A : TMR_A;
      end else if (ret_restore) begin
        in_service <= 1'b0;
      end
    end
  end

  // Assertions
  assert_take_one_clk_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
  assert_bank_low_R8: assert property (@(posedge clk) disable iff (rst)
    !vec_addr[BANK_BIT]);
  assert_take_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(take) |-> $past(sample_stb));
  assert_no_take_in_service_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(take) |-> !$past(in_service));
  assert_take_sets_service_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> in_service);
  assert_release_by_return_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(in_service) |-> $past(ret_restore));
  assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !ext_en && !tmr_en) |=> !take);
endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req_n = 1'b1, tmr_ovf = 1'b0, sample_stb = 1'b0;
  logic ext_en = 1'b0, tmr_en = 1'b0, ret_restore = 1'b0;
  logic take, in_service;
  logic [11:0] vec_addr;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  // reference model state
  int m_take = 0, m_vec = 0, m_svc = 0, m_pend = 0;

  irq_vec_ctrl dut (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .tmr_ovf(tmr_ovf),
    .sample_stb(sample_stb), .ext_en(ext_en), .tmr_en(tmr_en),
    .ret_restore(ret_restore), .take(take), .vec_addr(vec_addr),
    .in_service(in_service)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int ext_ok, tmr_ok, old_svc;
    cycles++;
    if (rst) begin
      m_take = 0; m_vec = 0; m_svc = 0; m_pend = 0;
    end else begin
      old_svc = m_svc;
      ext_ok = (ext_en && !ext_req_n) ? 1 : 0;
      tmr_ok = (tmr_en && (m_pend || tmr_ovf)) ? 1 : 0;
      m_pend = tmr_ok;
      m_take = 0;
      if (sample_stb && !old_svc && (ext_ok || tmr_ok)) begin
        m_take = 1;
        m_svc = 1;
        if (ext_ok) m_vec = 3;
        else begin m_vec = 7; m_pend = 0; end
      end else if (ret_restore) begin
        m_svc = 0;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    check(phase, "take", int'(take), m_take);
    check(phase, "in_service", int'(in_service), m_svc);
    check(phase, "vec_addr", int'(vec_addr), m_vec);
    check("R8", "bank bit", int'(vec_addr[11]), 0);
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    sample_stb = 1'b1; step(1); sample_stb = 1'b0;
  endtask

  task automatic do_return();
    ret_restore = 1'b1; step(1); ret_restore = 1'b0;
  endtask

  initial begin
    step(3);
    check("R1", "take in reset", int'(take), 0);
    check("R1", "in_service in reset", int'(in_service), 0);
    rst = 1'b0;
    step(2);

    phase = "R2";
    ext_en = 1'b1; ext_req_n = 1'b0;
    strobe();
    check("R2", "take after strobe", int'(take), 1);
    check("R2", "vector ext", int'(vec_addr), 3);
    step(1);
    check("R8", "take one clock", int'(take), 0);
    ext_req_n = 1'b1;
    step(2);
    phase = "R6";
    do_return();
    check("R6", "returned", int'(in_service), 0);
    do_return();
    check("R6", "idle return", int'(in_service), 0);

    phase = "R3";
    ext_req_n = 1'b0;
    step(5);
    check("R3", "no strobe no take", int'(in_service), 0);
    strobe();
    ext_req_n = 1'b1;
    step(2);
    do_return();

    phase = "R4";
    tmr_en = 1'b1;
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    step(4);
    strobe();
    check("R4", "timer vector", int'(vec_addr), 7);
    step(2);
    do_return();
    tmr_ovf = 1'b1; sample_stb = 1'b1; step(1);
    tmr_ovf = 1'b0; sample_stb = 1'b0;
    check("R4", "same-edge overflow", int'(take), 1);
    step(1); do_return();

    phase = "R5";
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    ext_req_n = 1'b0;
    strobe();
    check("R5", "external wins", int'(vec_addr), 3);
    ext_req_n = 1'b1;
    step(2);
    do_return();
    step(1);
    strobe();
    check("R5", "timer after return", int'(vec_addr), 7);
    step(1);

    phase = "R6";
    ext_req_n = 1'b0;
    strobe(); strobe();
    check("R6", "locked out", int'(take), 0);
    ext_req_n = 1'b1;
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    strobe();
    do_return();
    strobe();
    check("R6", "overflow held over service", int'(vec_addr), 7);
    step(1); do_return();

    phase = "R7";
    ext_en = 1'b0; ext_req_n = 1'b0;
    strobe(); step(1);
    check("R7", "ext disabled", int'(in_service), 0);
    ext_req_n = 1'b1;
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    tmr_en = 1'b0; step(1);
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    tmr_en = 1'b1; step(1);
    strobe(); step(1);
    check("R7", "pending dropped", int'(in_service), 0);

    phase = "R9";
    ext_en = 1'b1;
    step(1); ext_req_n = 1'b0; step(2); ext_req_n = 1'b1; step(1);
    strobe(); step(1);
    check("R9", "glitch between strobes", int'(in_service), 0);

    phase = "R1";
    ext_req_n = 1'b0; strobe(); ext_req_n = 1'b1;
    rst = 1'b1; step(2); rst = 1'b0;
    check("R1", "reset clears service", int'(in_service), 0);
    step(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule